// File: doc/BRIEF.md
# Latched-Address One-of-N Low Decoder

This block turns a binary select value into a single active-low strobe among `2**SEL_W` lines, eight by default. A hold register sits in front of the decoder. While the hold input is low, the select bus passes straight through to the decoder in the same cycle. The first clock edge that sees the hold input high stores the select value present at that edge. From then on the outputs ignore the select bus until the hold input drops again.

Two output gates, one active-high and one active-low, act directly on the strobe lines. When either gate is off, every line is forced high. The gates never disturb the stored address, so the held line comes back as soon as both gates are on again.

A typical use is chip-select generation. The address is presented once and held while the address bus moves on, and the strobes are pulsed through the gates.

Top module: `lat_decoder`

## Requirements
- R1: With both gates on, exactly one output is low: output n, where n is the unsigned value of `selIn` (bit 0 least significant; for the 3-bit default, bit 2 is the most significant). All other outputs are high.
- R2: While `holdEn` is low, the outputs follow `selIn` combinationally in the same cycle, with no clock delay.
- R3: The first rising clock edge at which `holdEn` is sampled high stores the `selIn` value present at that edge. Before that edge, the path remains transparent.
- R4: After that edge, and while `holdEn` stays high, changes on `selIn` have no effect on the outputs.
- R5: When `gateOn` is low, all outputs are high.
- R6: When `gateOffN` is high, all outputs are high.
- R7: The gates force the outputs high regardless of `selIn` and of whether the hold register is open or closed.
- R8: The stored address survives any period with the gates off. The same output goes low again when the gates reopen while `holdEn` is still high.
- R9: While `rstN` is low, the hold register is open and the stored address is cleared to zero, so the outputs follow `selIn` under the gates.
- R10: When `holdEn` returns low, the outputs follow `selIn` again in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples `holdEn` and stores the address |
| rstN | input | 1 | Asynchronous active-low reset |
| selIn | input | SEL_W | Binary select value |
| holdEn | input | 1 | High holds the address; low makes the path transparent |
| gateOn | input | 1 | Active-high output gate |
| gateOffN | input | 1 | Active-low output gate |
| yN | output | 2**SEL_W | Active-low decoded outputs |

## Verification
A stored address that is wrong, or that was stored on the wrong edge, shows up at the port in the first cycle after the hold closes: the low output then differs from the one the held select value names. The same mismatch appears again in every cycle the gates are on while the hold stays closed. If the hold register leaks, the low output moves within the cycle in which `selIn` changes. A faulty gate path shows as a low line in a cycle where every line should be high, or as all lines high while both gates are on. The reference model is compared with the outputs on every clock, so each of these faults is reported in the cycle where it first becomes visible.

// File: rtl/lat_decoder_pkg.sv
package lat_decoder_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // store selIn at this edge
    logic closed;   // decode from the stored address
    logic outOn;    // both gates enable the outputs
  } decStrobes_t;
endpackage

// File: rtl/lat_decoder_ctrl.sv
module lat_decoder_ctrl
  import lat_decoder_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        holdEn,
  input  logic        gateOn,
  input  logic        gateOffN,
  output decStrobes_t strb
);
  logic holdSeen;  // holdEn was high at the previous edge

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdSeen <= 1'b0;
    else       holdSeen <= holdEn;
  end

  always_comb begin
    strb.capture = holdEn & ~holdSeen & rstN;
    strb.closed  = holdEn & holdSeen;
    strb.outOn   = gateOn & ~gateOffN;
  end
endmodule

// File: rtl/lat_decoder_dp.sv
module lat_decoder_dp
  import lat_decoder_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   selIn,
  input  decStrobes_t        strb,
  output logic [(1<<SEL_W)-1:0] yN
);
  localparam int OUT_N = 1 << SEL_W;

  logic [SEL_W-1:0] heldAddr;
  logic [SEL_W-1:0] effAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             heldAddr <= '0;
    else if (strb.capture) heldAddr <= selIn;
  end

  assign effAddr = strb.closed ? heldAddr : selIn;

  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign yN[i] = ~(strb.outOn && (effAddr == SEL_W'(i)));
  end
endmodule

// File: rtl/lat_decoder.sv
module lat_decoder
  import lat_decoder_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [SEL_W-1:0]      selIn,
  input  logic                  holdEn,
  input  logic                  gateOn,
  input  logic                  gateOffN,
  output logic [(1<<SEL_W)-1:0] yN
);
  decStrobes_t strb;

  lat_decoder_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .holdEn(holdEn),
    .gateOn(gateOn), .gateOffN(gateOffN), .strb(strb)
  );

  lat_decoder_dp #(.SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .selIn(selIn), .strb(strb), .yN(yN)
  );
endmodule

// File: rtl/lat_decoder_chk.sv
module lat_decoder_chk #(
  parameter int SEL_W = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [SEL_W-1:0]      selIn,
  input logic                  holdEn,
  input logic                  gateOn,
  input logic                  gateOffN,
  input logic [(1<<SEL_W)-1:0] yN
);
  localparam int OUT_N = 1 << SEL_W;

  logic armed;
  logic outOn;
  assign outOn = gateOn & ~gateOffN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  p_one_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    outOn |-> $countones(~yN) == 1);

  p_follow_open_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!holdEn && outOn) |-> (~yN) == (OUT_N'(1) << selIn));

  p_hold_steady_r4: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (holdEn && $past(holdEn) && outOn && $past(outOn)) |-> $stable(yN));

  p_gate_hi_r5: assert property (@(posedge clk) disable iff (!rstN)
    !gateOn |-> &yN);

  p_gate_lo_r6: assert property (@(posedge clk) disable iff (!rstN)
    gateOffN |-> &yN);
endmodule

bind lat_decoder lat_decoder_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .selIn(selIn), .holdEn(holdEn),
  .gateOn(gateOn), .gateOffN(gateOffN), .yN(yN)
);

// File: tb/lat_decoder_tb.sv
module lat_decoder_tb;
  localparam int SEL_W = 3;
  localparam int OUT_N = 1 << SEL_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [SEL_W-1:0] selIn = '0;
  logic holdEn = 1'b0;
  logic gateOn = 1'b1;
  logic gateOffN = 1'b0;
  logic [OUT_N-1:0] yN;

  int runCnt = 0;
  int failCnt = 0;
  string phase = "R9";
  bit done = 1'b0;

  // reference model state
  int refHeld = 0;
  bit refPrev = 1'b0;

  always #5 clk = ~clk;

  lat_decoder #(.SEL_W(SEL_W)) u_dut (
    .clk(clk), .rstN(rstN), .selIn(selIn), .holdEn(holdEn),
    .gateOn(gateOn), .gateOffN(gateOffN), .yN(yN)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refHeld <= 0;
      refPrev <= 1'b0;
    end else begin
      if (holdEn && !refPrev) refHeld <= int'(selIn);
      refPrev <= holdEn;
    end
  end

  function automatic logic [OUT_N-1:0] expected();
    int addr;
    logic [OUT_N-1:0] e;
    addr = (holdEn && refPrev) ? refHeld : int'(selIn);
    e = '1;
    if (gateOn && !gateOffN) e[addr] = 1'b0;
    return e;
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      logic [OUT_N-1:0] e;
      e = expected();
      runCnt++;
      if (yN !== e) begin
        failCnt++;
        $display("FAIL %s: yN=%b expected=%b (sel=%0d hold=%b gOn=%b gOffN=%b)",
                 phase, yN, e, selIn, holdEn, gateOn, gateOffN);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    // R9: reset with hold high, outputs still follow selIn
    holdEn = 1'b1;
    selIn = 3'd6;
    step(2);
    selIn = 3'd2;
    step(1);
    rstN = 1'b1;
    holdEn = 1'b0;
    step(1);

    // R1 / R2: sweep every address while open
    phase = "R1/R2";
    for (int i = 0; i < OUT_N; i++) begin
      selIn = SEL_W'(i);
      step(1);
    end

    // R3: raise hold and change sel before the edge; transparent until the edge
    phase = "R3";
    selIn = 3'd5;
    holdEn = 1'b1;
    step(1);

    // R4: selIn moves while closed
    phase = "R4";
    for (int i = 0; i < OUT_N; i++) begin
      selIn = SEL_W'(i);
      step(1);
    end

    // R5 / R7: active-high gate off while closed, sel moving
    phase = "R5/R7";
    gateOn = 1'b0;
    for (int i = 0; i < 4; i++) begin
      selIn = SEL_W'(i + 2);
      step(1);
    end
    gateOn = 1'b1;

    // R8: stored address returns
    phase = "R8";
    step(2);

    // R6 / R7: active-low gate off, then open the hold while gated
    phase = "R6/R7";
    gateOffN = 1'b1;
    step(2);
    holdEn = 1'b0;
    selIn = 3'd1;
    step(2);
    gateOffN = 1'b0;

    // R10: reopen follows immediately
    phase = "R10";
    holdEn = 1'b1;
    selIn = 3'd3;
    step(2);
    selIn = 3'd7;
    step(1);
    holdEn = 1'b0;
    step(1);
    selIn = 3'd0;
    step(1);

    // R9: reset mid-run while closed
    phase = "R9";
    holdEn = 1'b1;
    selIn = 3'd4;
    step(2);
    rstN = 1'b0;
    selIn = 3'd6;
    step(2);
    rstN = 1'b1;
    step(2);

    // mixed stimulus over all inputs
    phase = "R1/R3/R4/R7";
    for (int i = 0; i < 400; i++) begin
      selIn = SEL_W'($urandom);
      if (($urandom % 4) == 0) holdEn = ~holdEn;
      gateOn = (($urandom % 6) != 0);
      gateOffN = (($urandom % 7) == 0);
      step(1);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      failCnt++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end
endmodule